// File: doc/BRIEF.md
# UART Infrared Line Interface

This block sits between the serial shift logic of a UART channel and the channel's pins. It converts the transmit bit stream into short infrared light pulses and turns received light pulses back into an ordinary NRZ bit stream. All timing comes from a one-cycle sample enable that fires sixteen times per bit. The same block also handles the modem control lines and a diagnostic loopback path.

Infrared operation is chosen by a mode bit. A global input loads this bit at reset, so every channel can power up with the emitter dark. After reset, software owns the bit. While infrared mode is active, the receiver is blanked whenever the transmitter reports that it is busy, so the channel never decodes its own reflected light. The receive polarity can be inverted for optical modules that drive active-low pulses. Loopback sends transmit data straight back to the receiver, parks the outgoing lines at their inactive levels and ignores the incoming status pins.

The block's outputs are registered. Asynchronous pins pass through a synchroniser before any logic uses them.

Top module: `uart_ir_line`

## Requirements
- R1: While `rst` is high, `ir_mode` takes the value of `glob_ir_en`, and `tx_pin` is 0 if `glob_ir_en` is 1 and 1 otherwise. Also during reset, `rx_ser`, `rts_n` and `dtr_n` are 1, and `cts`, `dsr`, `dcd` and `ri` are 0.
- R2: After reset, `ir_mode` changes only on a cycle with `ir_wr_en` high, and then takes `ir_wr_val` one clock later. Later changes on `glob_ir_en` have no effect.
- R3: With `ir_mode`=0 and `lpbk`=0, `tx_pin` equals `tx_ser` one clock later. `rx_ser` follows `rx_pin` after a two-flop synchroniser and one output register.
- R4: The encoder keeps a sample index. On a sample tick, the index is 0 if `tx_bit_start` is high; otherwise it is the previous tick's index plus 1, modulo 16. In infrared mode without loopback, `tx_pin` is 1 after a tick whose index is 7, 8 or 9 and whose `tx_ser` is 0. After every other tick, `tx_pin` is 0, so the line idles low.
- R5: In infrared mode, a pulse is a synchronised `rx_pin` of 1 when `rx_inv`=0, or 0 when `rx_inv`=1. A tick that sees a pulse drives `rx_ser` to 0 for that tick and the following 15 ticks. Each new pulse restarts this count of 16. With no pulse pending, `rx_ser` is 1.
- R6: While `ir_mode`=1 and `tx_busy`=1, `rx_ser` is 1 and any pending low stretch is discarded. Leaving infrared mode also discards the stretch.
- R7: With `lpbk`=1, in either mode, `tx_pin` is 1 and `rx_ser` equals `tx_ser` one clock later, and `rts_n` and `dtr_n` are 1.
- R8: With `lpbk`=0, `rts_n`=!`rts_req` and `dtr_n`=!`dtr_req` one clock later. `cts`, `dsr`, `dcd` and `ri` are the inverses of `cts_n_pin`, `dsr_n_pin`, `dcd_n_pin` and `ri_n_pin` respectively, after the synchroniser and one register.
- R9: With `lpbk`=1, `cts`=`rts_req` and `dsr`=`dtr_req` one clock later, `dcd`=0 and `ri`=0, and the four status pins are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Sample tick, sixteen per bit period |
| glob_ir_en | input | 1 | Global infrared enable, loaded into the mode bit at reset |
| ir_wr_en | input | 1 | Software write strobe for the mode bit |
| ir_wr_val | input | 1 | Value written to the mode bit |
| rx_inv | input | 1 | Accept active-low infrared pulses |
| lpbk | input | 1 | Internal loopback enable |
| tx_ser | input | 1 | Raw transmit serial data |
| tx_busy | input | 1 | Transmitter is sending |
| tx_bit_start | input | 1 | Marks the first tick of a transmit bit cell |
| rx_pin | input | 1 | Receive pin |
| rts_req | input | 1 | Request-to-send from the UART, active high |
| dtr_req | input | 1 | Terminal-ready from the UART, active high |
| cts_n_pin | input | 1 | Clear-to-send pin, active low |
| dsr_n_pin | input | 1 | Data-set-ready pin, active low |
| dcd_n_pin | input | 1 | Carrier-detect pin, active low |
| ri_n_pin | input | 1 | Ring-indicator pin, active low |
| tx_pin | output | 1 | Transmit pin |
| rx_ser | output | 1 | Recovered receive bit stream |
| ir_mode | output | 1 | Current infrared mode bit |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| cts | output | 1 | Clear-to-send status to the UART |
| dsr | output | 1 | Data-set-ready status to the UART |
| dcd | output | 1 | Carrier-detect status to the UART |
| ri | output | 1 | Ring-indicator status to the UART |

## Verification
The bench walks every sample index of full ten-bit frames and also forces an early bit boundary. An encoder whose pulse window is shifted, or whose counter does not realign on `tx_bit_start`, would therefore light up in the wrong ticks.

For the decoder, the bench sends single pulses and a pulse that arrives mid-stretch, in both polarities. A stretch that is one tick short, one that does not restart on the second pulse, or an inverted polarity would each show up as a wrong `rx_ser` bit.

The bench also raises `tx_busy` during a pending stretch to catch an echo that leaks through. It sweeps every status pin combination with and without loopback, which exposes a pin that is not ignored or a control line that is not parked.

// File: rtl/uart_ir_pkg.sv
package uart_ir_pkg;

  typedef enum logic [1:0] {
    PATH_WIRE = 2'd0,
    PATH_IR   = 2'd1,
    PATH_LOOP = 2'd2
  } line_path_e;

  // Loopback overrides infrared, which overrides the plain wire path.
  function automatic line_path_e pick_path(input logic ir_on, input logic loop_on);
    if (loop_on)    return PATH_LOOP;
    else if (ir_on) return PATH_IR;
    else            return PATH_WIRE;
  endfunction

endpackage

// File: rtl/uart_ir_sync.sv
module uart_ir_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/uart_ir_enc.sv
module uart_ir_enc #(
  parameter int OSR         = 16,
  parameter int PULSE_START = 7,
  parameter int PULSE_LEN   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic bit_start,
  input  logic ser_in,
  output logic pulse_o
);

  localparam int PW = $clog2(OSR);

  logic [PW-1:0] ph_q;
  logic [PW-1:0] idx;
  logic          in_win;

  always_comb begin
    idx    = bit_start ? '0 : ph_q;
    in_win = (int'(idx) >= PULSE_START) && (int'(idx) < PULSE_START + PULSE_LEN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= '0;
      pulse_o <= 1'b0;
    end else if (samp_en) begin
      ph_q    <= (int'(idx) == OSR - 1) ? '0 : idx + PW'(1);
      pulse_o <= !ser_in && in_win;
    end
  end

endmodule

// File: rtl/uart_ir_dec.sv
module uart_ir_dec #(
  parameter int STRETCH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic clear,
  input  logic pulse_in,
  output logic data_o
);

  localparam int CW = $clog2(STRETCH + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (samp_en) begin
      if (pulse_in)          cnt_q <= CW'(STRETCH);
      else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end
  end

  assign data_o = (cnt_q == '0);

endmodule

// File: rtl/uart_ir_line.sv
module uart_ir_line
  import uart_ir_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int PULSE_START = 7,
  parameter int PULSE_LEN   = 3,
  parameter int STRETCH     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_en,
  input  logic glob_ir_en,
  input  logic ir_wr_en,
  input  logic ir_wr_val,
  input  logic rx_inv,
  input  logic lpbk,
  input  logic tx_ser,
  input  logic tx_busy,
  input  logic tx_bit_start,
  input  logic rx_pin,
  input  logic rts_req,
  input  logic dtr_req,
  input  logic cts_n_pin,
  input  logic dsr_n_pin,
  input  logic dcd_n_pin,
  input  logic ri_n_pin,
  output logic tx_pin,
  output logic rx_ser,
  output logic ir_mode,
  output logic rts_n,
  output logic dtr_n,
  output logic cts,
  output logic dsr,
  output logic dcd,
  output logic ri
);

  localparam int NSYNC = 5;

  logic             ir_q;
  logic [NSYNC-1:0] pin_raw, pin_s;
  logic             s_rx, s_cts_n, s_dsr_n, s_dcd_n, s_ri_n;
  logic             enc_pulse, dec_data, dec_clear, ir_pulse;
  line_path_e       path;

  logic tx_q, rx_q, rts_n_q, dtr_n_q, cts_q, dsr_q, dcd_q, ri_q;

  // Mode bit: captured from the global pin at reset, then software-owned.
  always_ff @(posedge clk) begin
    if (rst)           ir_q <= glob_ir_en;
    else if (ir_wr_en) ir_q <= ir_wr_val;
  end

  assign pin_raw = {ri_n_pin, dcd_n_pin, dsr_n_pin, cts_n_pin, rx_pin};

  uart_ir_sync #(
    .WIDTH   (NSYNC),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (5'b11110)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pin_raw),
    .dout (pin_s)
  );

  assign {s_ri_n, s_dcd_n, s_dsr_n, s_cts_n, s_rx} = pin_s;

  uart_ir_enc #(
    .OSR         (OSR),
    .PULSE_START (PULSE_START),
    .PULSE_LEN   (PULSE_LEN)
  ) u_enc (
    .clk       (clk),
    .rst       (rst),
    .samp_en   (samp_en),
    .bit_start (tx_bit_start),
    .ser_in    (tx_ser),
    .pulse_o   (enc_pulse)
  );

  assign ir_pulse  = s_rx ^ rx_inv;
  assign dec_clear = !ir_q || tx_busy;

  uart_ir_dec #(
    .STRETCH (STRETCH)
  ) u_dec (
    .clk      (clk),
    .rst      (rst),
    .samp_en  (samp_en),
    .clear    (dec_clear),
    .pulse_in (ir_pulse),
    .data_o   (dec_data)
  );

  assign path = pick_path(ir_q, lpbk);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= !glob_ir_en;
      rx_q    <= 1'b1;
      rts_n_q <= 1'b1;
      dtr_n_q <= 1'b1;
      cts_q   <= 1'b0;
      dsr_q   <= 1'b0;
      dcd_q   <= 1'b0;
      ri_q    <= 1'b0;
    end else begin
      unique case (path)
        PATH_LOOP: begin
          tx_q <= 1'b1;
          rx_q <= tx_ser;
        end
        PATH_IR: begin
          tx_q <= enc_pulse;
          rx_q <= dec_data;
        end
        default: begin
          tx_q <= tx_ser;
          rx_q <= s_rx;
        end
      endcase
      if (path == PATH_LOOP) begin
        rts_n_q <= 1'b1;
        dtr_n_q <= 1'b1;
        cts_q   <= rts_req;
        dsr_q   <= dtr_req;
        dcd_q   <= 1'b0;
        ri_q    <= 1'b0;
      end else begin
        rts_n_q <= !rts_req;
        dtr_n_q <= !dtr_req;
        cts_q   <= !s_cts_n;
        dsr_q   <= !s_dsr_n;
        dcd_q   <= !s_dcd_n;
        ri_q    <= !s_ri_n;
      end
    end
  end

  assign tx_pin  = tx_q;
  assign rx_ser  = rx_q;
  assign ir_mode = ir_q;
  assign rts_n   = rts_n_q;
  assign dtr_n   = dtr_n_q;
  assign cts     = cts_q;
  assign dsr     = dsr_q;
  assign dcd     = dcd_q;
  assign ri      = ri_q;

endmodule

// File: rtl/uart_ir_line_chk.sv
module uart_ir_line_chk (
  input logic clk,
  input logic rst,
  input logic ir_wr_en,
  input logic ir_wr_val,
  input logic lpbk,
  input logic tx_ser,
  input logic tx_busy,
  input logic rts_req,
  input logic dtr_req,
  input logic tx_pin,
  input logic rx_ser,
  input logic ir_mode,
  input logic rts_n,
  input logic dtr_n,
  input logic cts,
  input logic dsr,
  input logic dcd,
  input logic ri
);

  a_r7_loop_tx_mark: assert property (@(posedge clk) disable iff (rst)
    lpbk |=> tx_pin);

  a_r7_loop_ctl_off: assert property (@(posedge clk) disable iff (rst)
    lpbk |=> (rts_n && dtr_n));

  a_r9_loop_status: assert property (@(posedge clk) disable iff (rst)
    lpbk |=> (cts == $past(rts_req) && dsr == $past(dtr_req) && !dcd && !ri));

  a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !ir_wr_en |=> $stable(ir_mode));

  a_r2_mode_write: assert property (@(posedge clk) disable iff (rst)
    ir_wr_en |=> (ir_mode == $past(ir_wr_val)));

  a_r3_wire_tx: assert property (@(posedge clk) disable iff (rst)
    (!ir_mode && !lpbk) |=> (tx_pin == $past(tx_ser)));

  a_r6_echo_blank: assert property (@(posedge clk) disable iff (rst)
    (ir_mode && tx_busy && !lpbk) ##1 (ir_mode && !lpbk) |=> rx_ser);

  a_r8_ctl_wire: assert property (@(posedge clk) disable iff (rst)
    !lpbk |=> (rts_n == !$past(rts_req) && dtr_n == !$past(dtr_req)));

endmodule

bind uart_ir_line uart_ir_line_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ir_wr_en  (ir_wr_en),
  .ir_wr_val (ir_wr_val),
  .lpbk      (lpbk),
  .tx_ser    (tx_ser),
  .tx_busy   (tx_busy),
  .rts_req   (rts_req),
  .dtr_req   (dtr_req),
  .tx_pin    (tx_pin),
  .rx_ser    (rx_ser),
  .ir_mode   (ir_mode),
  .rts_n     (rts_n),
  .dtr_n     (dtr_n),
  .cts       (cts),
  .dsr       (dsr),
  .dcd       (dcd),
  .ri        (ri)
);

// File: tb/tb_uart_ir_line.sv
`timescale 1ns/1ps
module tb_uart_ir_line;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic samp_en = 1'b0, glob_ir_en = 1'b0, ir_wr_en = 1'b0, ir_wr_val = 1'b0;
  logic rx_inv = 1'b0, lpbk = 1'b0, tx_ser = 1'b1, tx_busy = 1'b0, tx_bit_start = 1'b0;
  logic rx_pin = 1'b1, rts_req = 1'b0, dtr_req = 1'b0;
  logic cts_n_pin = 1'b1, dsr_n_pin = 1'b1, dcd_n_pin = 1'b1, ri_n_pin = 1'b1;
  logic tx_pin, rx_ser, ir_mode, rts_n, dtr_n, cts, dsr, dcd, ri;

  int checks = 0;
  int errors = 0;
  logic       m_ir = 1'b0;
  logic [3:0] m_ph = 4'd0;
  int         m_cnt = 0;

  always #2.5 clk = ~clk;

  uart_ir_line dut (
    .clk(clk), .rst(rst), .samp_en(samp_en), .glob_ir_en(glob_ir_en),
    .ir_wr_en(ir_wr_en), .ir_wr_val(ir_wr_val), .rx_inv(rx_inv), .lpbk(lpbk),
    .tx_ser(tx_ser), .tx_busy(tx_busy), .tx_bit_start(tx_bit_start),
    .rx_pin(rx_pin), .rts_req(rts_req), .dtr_req(dtr_req),
    .cts_n_pin(cts_n_pin), .dsr_n_pin(dsr_n_pin), .dcd_n_pin(dcd_n_pin),
    .ri_n_pin(ri_n_pin), .tx_pin(tx_pin), .rx_ser(rx_ser), .ir_mode(ir_mode),
    .rts_n(rts_n), .dtr_n(dtr_n), .cts(cts), .dsr(dsr), .dcd(dcd), .ri(ri)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic g);
    glob_ir_en = g;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ir_mode", ir_mode, g);
    chk("R1", "tx_pin", tx_pin, !g);
    chk("R1", "rx_ser", rx_ser, 1'b1);
    chk("R1", "rts_n", rts_n, 1'b1);
    chk("R1", "dtr_n", dtr_n, 1'b1);
    chk("R1", "status", cts | dsr | dcd | ri, 1'b0);
    rst = 1'b0;
    m_ir = g; m_ph = 4'd0; m_cnt = 0;
    @(negedge clk);
  endtask

  task automatic wr_ir(input logic v);
    ir_wr_en = 1'b1; ir_wr_val = v;
    @(negedge clk);
    ir_wr_en = 1'b0;
    m_ir = v;
    if (!v) m_cnt = 0;
    chk("R2", "ir_mode write", ir_mode, v);
  endtask

  // One sample tick; inputs set by the caller are held across it.
  task automatic do_tick(input string rt, input string rr);
    logic [3:0] idx;
    logic pulse, det, etx, erx;
    repeat (2) @(negedge clk);
    samp_en = 1'b1;
    @(negedge clk);
    samp_en = 1'b0;
    @(negedge clk);
    idx   = tx_bit_start ? 4'd0 : m_ph;
    pulse = !tx_ser && (idx >= 4'd7) && (idx <= 4'd9);
    m_ph  = idx + 4'd1;
    det   = rx_inv ? !rx_pin : rx_pin;
    if (!m_ir || tx_busy) m_cnt = 0;
    else if (det)         m_cnt = 16;
    else if (m_cnt > 0)   m_cnt = m_cnt - 1;
    etx = lpbk ? 1'b1 : (m_ir ? pulse : tx_ser);
    erx = lpbk ? tx_ser : (m_ir ? (m_cnt == 0) : rx_pin);
    chk(rt, "tx_pin", tx_pin, etx);
    chk(rr, "rx_ser", rx_ser, erx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] frame;
    @(negedge clk);

    // R1 reset values for both global settings
    do_reset(1'b1);
    do_reset(1'b0);

    // R2: global pin ignored after reset, software write owns the bit
    glob_ir_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2", "ir_mode ignores glob", ir_mode, 1'b0);
    wr_ir(1'b1);
    glob_ir_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", "ir_mode held", ir_mode, 1'b1);
    wr_ir(1'b0);

    // R3: wire mode, one-clock transmit latency and synchronised receive
    for (int i = 0; i < 8; i++) begin
      tx_ser = i[0]; rx_pin = i[1] ^ i[2];
      @(negedge clk);
      chk("R3", "tx_pin 1-clk", tx_pin, i[0]);
      do_tick("R3", "R3");
    end

    // R4: encoder over two full frames plus an early bit boundary
    wr_ir(1'b1);
    tx_busy = 1'b1;
    rx_pin = 1'b0;
    for (int f = 0; f < 2; f++) begin
      frame = (f == 0) ? {1'b1, 8'h4B, 1'b0} : {1'b1, 8'hB0, 1'b0};
      for (int b = 0; b < 10; b++) begin
        for (int s = 0; s < 16; s++) begin
          tx_ser = frame[b];
          tx_bit_start = (s == 0);
          do_tick("R4", "R6");
        end
      end
    end
    tx_bit_start = 1'b0;
    tx_ser = 1'b0;
    for (int s = 0; s < 22; s++) begin
      tx_bit_start = (s == 0) || (s == 5);
      do_tick("R4", "R6");
    end
    tx_bit_start = 1'b0;
    tx_ser = 1'b1;
    for (int s = 0; s < 4; s++) do_tick("R4", "R6");

    // R5: decoder stretch and retrigger in both polarities
    tx_busy = 1'b0;
    for (int p = 0; p < 2; p++) begin
      rx_inv = p[0];
      rx_pin = p[0];
      do_tick("R4", "R5");
      for (int t = 0; t < 48; t++) begin
        rx_pin = ((t == 0) || (t == 20) || (t == 28)) ^ p[0];
        do_tick("R4", "R5");
      end
    end
    rx_inv = 1'b0;
    rx_pin = 1'b0;

    // R6: blanking while transmitting drops a pending stretch and echoes
    rx_pin = 1'b1; do_tick("R4", "R5");
    rx_pin = 1'b0;
    for (int t = 0; t < 3; t++) do_tick("R4", "R5");
    tx_busy = 1'b1;
    for (int t = 0; t < 4; t++) begin
      rx_pin = t[0];
      do_tick("R4", "R6");
    end
    tx_busy = 1'b0;
    rx_pin = 1'b0;
    for (int t = 0; t < 4; t++) do_tick("R4", "R6");
    // leaving infrared mode discards a stretch
    rx_pin = 1'b1; do_tick("R4", "R5");
    rx_pin = 1'b0;
    wr_ir(1'b0);
    wr_ir(1'b1);
    do_tick("R4", "R6");

    // R7: loopback in both modes
    lpbk = 1'b1;
    rts_req = 1'b1; dtr_req = 1'b1;
    for (int m = 0; m < 2; m++) begin
      wr_ir(m[0]);
      for (int t = 0; t < 8; t++) begin
        tx_ser = t[0] ^ t[2];
        rx_pin = t[1];
        do_tick("R7", "R7");
        chk("R7", "rts_n parked", rts_n, 1'b1);
        chk("R7", "dtr_n parked", dtr_n, 1'b1);
      end
    end
    lpbk = 1'b0;
    wr_ir(1'b0);

    // R8 / R9: modem lines over all pin combinations, both modes
    for (int l = 0; l < 2; l++) begin
      lpbk = l[0];
      for (int m = 0; m < 16; m++) begin
        cts_n_pin = m[0]; dsr_n_pin = m[1]; dcd_n_pin = m[2]; ri_n_pin = m[3];
        rts_req = m[2]; dtr_req = m[3];
        repeat (4) @(negedge clk);
        if (l == 0) begin
          chk("R8", "rts_n", rts_n, !m[2]);
          chk("R8", "dtr_n", dtr_n, !m[3]);
          chk("R8", "cts", cts, !m[0]);
          chk("R8", "dsr", dsr, !m[1]);
          chk("R8", "dcd", dcd, !m[2]);
          chk("R8", "ri", ri, !m[3]);
        end else begin
          chk("R7", "rts_n", rts_n, 1'b1);
          chk("R7", "dtr_n", dtr_n, 1'b1);
          chk("R9", "cts", cts, m[2]);
          chk("R9", "dsr", dsr, m[3]);
          chk("R9", "dcd", dcd, 1'b0);
          chk("R9", "ri", ri, 1'b0);
        end
      end
    end
    lpbk = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule